// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of an eight-input successive-approximation converter. It picks the analog input, presents a trial code to an external 10-bit DAC, reads back one comparator bit per trial and builds the result from the most significant bit down. The comparator, resistor ladder and pad drivers sit outside. The block only drives the channel select and the DAC code, and samples the comparator.

Software sets the resolution (8 or 10 bits), a sample-and-hold timing profile, a conversion-clock divider and one of four modes: single conversion, repeated conversion of one input, one pass over inputs 0 to a chosen last input, or endless passes over that range. A conversion runs only after software sets the run flag while the reference is connected. Every channel takes a fixed number of conversion-clock ticks. The ticks left over after the bit trials form a sampling phase at the start of the channel. Results land in a 16-byte bank that a bus reads by byte address.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0, dac_code_o is 0 and all 16 result bytes read 0.
- R2: ladder_off_o equals the inverse of cfg_ref_en. A start_set pulse starts a run only while idle and while cfg_ref_en is 1. Otherwise it is ignored and busy_o stays 0.
- R3: cfg_div selects the conversion clock: 0 gives the input clock, 1 gives the input clock divided by 2, and 2 or 3 give it divided by 4.
- R4: Ticks per channel: 49 (8-bit), 59 (10-bit), 28 (8-bit with sample-and-hold) and 33 (10-bit with sample-and-hold). With divider D and T ticks, done_o is high in the cycle after the D*T-th rising edge that follows the edge accepting start_set. done_o is a one-cycle pulse.
- R5: Conversion is MSB-first. dac_code_o is 0 for the first T-N ticks, where N is the resolution. Trial k then sets DAC bit 9-k on top of the kept bits, and cmp_i=1 keeps that bit. With cmp_i = (input >= dac_code_o), the 10-bit result equals the input code and the 8-bit result equals the input code divided by 4.
- R6: In 10-bit mode, channel c writes result bits 7..0 to byte 2c and bits 9..8 to bits 1..0 of byte 2c+1. The upper bits of byte 2c+1 read 0.
- R7: In 8-bit mode, channel c writes the 8-bit result to byte 2c and leaves byte 2c+1 unchanged.
- R8: Mode 0 (single) converts input cfg_chan once. busy_o is 0 in the cycle in which done_o is high.
- R9: Mode 1 (repeat) converts input cfg_chan again and again. Successive done pulses are D*T cycles apart, and each pass stores a fresh result.
- R10: Mode 2 (single pass) converts inputs 0, 1, ... cfg_chan in ascending order with one done pulse each. In each pulse cycle ain_sel_o shows the next input. busy_o clears with the last pulse.
- R11: Mode 3 (endless pass) behaves like mode 2 but wraps from cfg_chan back to input 0 and keeps running.
- R12: start_clr stops a run, and busy_o is 0 on the next cycle with no further done pulse. start_set and configuration changes during a run have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ref_en | input | 1 | Reference connected to the ladder |
| cfg_mode | input | 2 | 0 single, 1 repeat, 2 single pass, 3 endless pass |
| cfg_chan | input | 3 | Input for single modes, last input for pass modes |
| cfg_res10 | input | 1 | 1 selects 10-bit, 0 selects 8-bit |
| cfg_sh | input | 1 | Sample-and-hold timing profile |
| cfg_div | input | 2 | Conversion-clock divider select |
| start_set | input | 1 | Software sets the run flag |
| start_clr | input | 1 | Software clears the run flag |
| busy_o | output | 1 | Run flag |
| done_o | output | 1 | One-cycle pulse per stored result |
| ladder_off_o | output | 1 | Disconnect the reference ladder |
| ain_sel_o | output | 3 | Selected analog input |
| dac_code_o | output | 10 | Trial code to the DAC |
| cmp_i | input | 1 | Comparator: input at or above the trial code |
| rd_addr | input | 4 | Result byte address |
| rd_data | output | 8 | Result byte |

## Verification
The hardest case to reach from the ports is a clean 8-bit result sitting next to a stale high byte that a 10-bit result left behind. The bench first converts a channel at 10 bits, then converts it again at 8 bits, and reads both bytes. A second hard case is a start request or a configuration change that arrives in the middle of a conversion. The bench injects one partway through a run and then checks that the timing, the target channel and the stored value all belong to the original request. A comparator model driven by the DAC code covers every resolution, profile and divider, with expected codes and cycle counts computed by arithmetic.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        MODE_ONCE      = 2'd0,
        MODE_REPEAT    = 2'd1,
        MODE_SWEEP     = 2'd2,
        MODE_SWEEP_RPT = 2'd3
    } sar_mode_e;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 2;

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        case (sel)
            2'd0:    limit = CNT_W'(0);
            2'd1:    limit = CNT_W'(1);
            default: limit = CNT_W'(3);
        endcase
        tick  = !clr && (cnt_q == limit);
        cnt_d = (clr || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a divided clock never ticks on two cycles in a row
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'd0) |=> !tick);
endmodule

// File: rtl/sar_resbank.sv
module sar_resbank #(
    parameter int NCH    = 8,
    parameter int BYTE_W = 8,
    parameter int HI_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_lo,
    input  logic                     we_hi,
    input  logic [$clog2(NCH)-1:0]   wchan,
    input  logic [BYTE_W-1:0]        lo,
    input  logic [HI_W-1:0]          hi,
    input  logic [$clog2(NCH):0]     raddr,
    output logic [BYTE_W-1:0]        rdata
);
    localparam int CH_W = $clog2(NCH);

    logic [BYTE_W-1:0] lo_arr [NCH];
    logic [HI_W-1:0]   hi_arr [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [BYTE_W-1:0] lo_d, lo_q;
        logic [HI_W-1:0]   hi_d, hi_q;
        always_comb begin
            lo_d = lo_q;
            hi_d = hi_q;
            if (we_lo && wchan == CH_W'(c)) lo_d = lo;
            if (we_hi && wchan == CH_W'(c)) hi_d = hi;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else begin
                lo_q <= lo_d;
                hi_q <= hi_d;
            end
        end
        assign lo_arr[c] = lo_q;
        assign hi_arr[c] = hi_q;
    end

    always_comb begin
        if (raddr[0]) rdata = BYTE_W'(hi_arr[raddr[CH_W:1]]);
        else          rdata = lo_arr[raddr[CH_W:1]];
    end

    // R6 R7: the odd byte is only ever written together with its even byte
    assert_hi_with_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |-> we_lo);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int RES_W       = 10,
    parameter int LO_W        = 8,
    parameter int BYTE_W      = 8,
    parameter int CYC_LO      = 49,
    parameter int CYC_HI      = 59,
    parameter int CYC_LO_SH   = 28,
    parameter int CYC_HI_SH   = 33
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_ref_en,
    input  logic [1:0]  cfg_mode,
    input  logic [2:0]  cfg_chan,
    input  logic        cfg_res10,
    input  logic        cfg_sh,
    input  logic [1:0]  cfg_div,
    input  logic        start_set,
    input  logic        start_clr,
    output logic        busy_o,
    output logic        done_o,
    output logic        ladder_off_o,
    output logic [2:0]  ain_sel_o,
    output logic [9:0]  dac_code_o,
    input  logic        cmp_i,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data
);
    localparam int CH_W  = $clog2(NCH);
    localparam int CNT_W = $clog2(CYC_HI + 1);
    localparam int HI_W  = RES_W - BYTE_W;
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  chan;
        logic [CH_W-1:0]  last;
        sar_mode_e        mode;
        logic             res10;
        logic             sh;
        logic [1:0]       div;
        logic [RES_W-1:0] sar;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    logic             tick;
    logic [CNT_W-1:0] total, nbits, samp, k;
    logic             in_trial, finish;
    logic [RES_W-1:0] dac_code, sar_new;
    logic [BYTE_W-1:0] wr_lo;
    logic [HI_W-1:0]   wr_hi;

    sar_clkdiv #(.SEL_W(2)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!st_q.run),
        .sel   (st_q.div),
        .tick  (tick)
    );

    always_comb begin
        if (st_q.res10) total = st_q.sh ? CNT_W'(CYC_HI_SH) : CNT_W'(CYC_HI);
        else            total = st_q.sh ? CNT_W'(CYC_LO_SH) : CNT_W'(CYC_LO);
        nbits    = st_q.res10 ? CNT_W'(RES_W) : CNT_W'(LO_W);
        samp     = total - nbits;
        in_trial = st_q.run && (st_q.cnt >= samp);
        k        = st_q.cnt - samp;
        dac_code = in_trial ? (st_q.sar | (MSB_ONE >> k)) : '0;
        sar_new  = (in_trial && cmp_i) ? dac_code : st_q.sar;
        finish   = st_q.run && !start_clr && tick && (st_q.cnt == total - CNT_W'(1));
        wr_lo    = st_q.res10 ? sar_new[BYTE_W-1:0] : sar_new[RES_W-1 -: LO_W];
        wr_hi    = sar_new[RES_W-1:BYTE_W];

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.run) begin
            if (start_set && cfg_ref_en) begin
                st_d.run   = 1'b1;
                st_d.cnt   = '0;
                st_d.sar   = '0;
                st_d.mode  = sar_mode_e'(cfg_mode);
                st_d.res10 = cfg_res10;
                st_d.sh    = cfg_sh;
                st_d.div   = cfg_div;
                st_d.last  = cfg_chan;
                st_d.chan  = cfg_mode[1] ? '0 : cfg_chan;
            end
        end else if (start_clr) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.sar = '0;
        end else if (tick) begin
            st_d.sar = sar_new;
            if (finish) begin
                st_d.done = 1'b1;
                st_d.cnt  = '0;
                st_d.sar  = '0;
                if (st_q.mode[1] && st_q.chan != st_q.last)
                    st_d.chan = st_q.chan + CH_W'(1);
                else if (st_q.mode[0])
                    st_d.chan = st_q.mode[1] ? '0 : st_q.chan;
                else
                    st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, cnt: '0, chan: '0, last: '0, mode: MODE_ONCE,
                      res10: 1'b0, sh: 1'b0, div: '0, sar: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    sar_resbank #(.NCH(NCH), .BYTE_W(BYTE_W), .HI_W(HI_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (finish),
        .we_hi (finish && st_q.res10),
        .wchan (st_q.chan),
        .lo    (wr_lo),
        .hi    (wr_hi),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign busy_o       = st_q.run;
    assign done_o       = st_q.done;
    assign ladder_off_o = !cfg_ref_en;
    assign ain_sel_o    = st_q.chan;
    assign dac_code_o   = dac_code;

    // R2: a run only begins from an accepted request with the reference connected
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(cfg_ref_en) && $past(start_set)));

    // R4: the completion flag lasts exactly one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a single conversion leaves the run flag clear when it completes
    assert_once_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.mode == MODE_ONCE) |-> !busy_o);

    // R10 R11: inside a run the input only steps upward or wraps to zero in pass modes
    assert_sweep_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && ain_sel_o != $past(ain_sel_o)) |->
        (st_q.mode[1] && (ain_sel_o == $past(ain_sel_o) + 3'd1 || ain_sel_o == 3'd0)));

    // R5: no trial code is presented while idle
    assert_idle_dac_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> dac_code_o == '0);
endmodule

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ref_en = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [2:0] cfg_chan = 3'd0;
    logic       cfg_res10 = 1'b0;
    logic       cfg_sh = 1'b0;
    logic [1:0] cfg_div = 2'd0;
    logic       start_set = 1'b0;
    logic       start_clr = 1'b0;
    logic       busy_o, done_o, ladder_off_o, cmp_i;
    logic [2:0] ain_sel_o;
    logic [9:0] dac_code_o;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;

    logic [9:0] vin [8];
    int exp_b [16];
    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign cmp_i = (vin[ain_sel_o] >= dac_code_o);

    sar_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ref_en(cfg_ref_en), .cfg_mode(cfg_mode),
        .cfg_chan(cfg_chan), .cfg_res10(cfg_res10), .cfg_sh(cfg_sh), .cfg_div(cfg_div),
        .start_set(start_set), .start_clr(start_clr), .busy_o(busy_o), .done_o(done_o),
        .ladder_off_o(ladder_off_o), .ain_sel_o(ain_sel_o), .dac_code_o(dac_code_o),
        .cmp_i(cmp_i), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ticks(input bit r10, input bit sh);
        if (r10) return sh ? 33 : 59;
        return sh ? 28 : 49;
    endfunction

    function automatic int divf(input int d);
        return (d == 0) ? 1 : (d == 1) ? 2 : 4;
    endfunction

    task automatic rd(input int a, output int v);
        rd_addr = 4'(a);
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_set = 1'b1;
        @(negedge clk); start_set = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (done_o) return;
        end
        n = -1;
    endtask

    task automatic expect_store(input int ch, input bit r10, input string req);
        int v;
        if (r10) begin
            exp_b[2*ch]   = int'(vin[ch]) & 255;
            exp_b[2*ch+1] = int'(vin[ch]) >> 8;
        end else begin
            exp_b[2*ch]   = int'(vin[ch]) >> 2;
        end
        rd(2*ch, v);   chk(v == exp_b[2*ch],   req, v, exp_b[2*ch]);
        rd(2*ch+1, v); chk(v == exp_b[2*ch+1], req, v, exp_b[2*ch+1]);
    endtask

    task automatic one_shot(input int ch, input int d, input bit r10, input bit sh);
        int n;
        cfg_mode = 2'd0; cfg_chan = 3'(ch); cfg_div = 2'(d);
        cfg_res10 = r10; cfg_sh = sh;
        pulse_start();
        wait_done(n);
        chk(n == divf(d) * ticks(r10, sh), "R4 R3 cycle count", n, divf(d) * ticks(r10, sh));
        chk(busy_o == 1'b0, "R8 busy clear at done", int'(busy_o), 0);
        expect_store(ch, r10, r10 ? "R5 R6 10-bit store" : "R5 R7 8-bit store");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n, v;
        for (int c = 0; c < 8; c++) vin[c] = 10'd0;
        for (int a = 0; a < 16; a++) exp_b[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy_o == 0, "R1 busy", int'(busy_o), 0);
        chk(done_o == 0, "R1 done", int'(done_o), 0);
        chk(dac_code_o == 0, "R1 dac", int'(dac_code_o), 0);
        for (int a = 0; a < 16; a++) begin
            rd(a, v); chk(v == 0, "R1 bank", v, 0);
        end

        // R2: reference disconnected blocks the start
        chk(ladder_off_o == 1, "R2 ladder off", int'(ladder_off_o), 1);
        pulse_start();
        repeat (10) @(negedge clk);
        chk(busy_o == 0, "R2 start ignored", int'(busy_o), 0);
        cfg_ref_en = 1'b1;
        #0.5;
        chk(ladder_off_o == 0, "R2 ladder on", int'(ladder_off_o), 0);

        // R3 R4 R5 R6 R7 R8: every divider, resolution and profile
        for (int d = 0; d < 4; d++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 2; s++) begin
                    int ch = (d * 4 + r * 2 + s) % 8;
                    vin[ch] = 10'((d * 211 + r * 97 + s * 53 + ch * 131 + 5) % 1024);
                    one_shot(ch, d, r[0], s[0]);
                end

        // R5: range ends
        vin[1] = 10'd0;    one_shot(1, 0, 1'b1, 1'b0);
        vin[2] = 10'd1023; one_shot(2, 0, 1'b1, 1'b1);
        vin[3] = 10'd1023; one_shot(3, 0, 1'b0, 1'b1);

        // R7: 8-bit rewrite keeps a stale odd byte
        vin[5] = 10'h3FF; one_shot(5, 0, 1'b1, 1'b1);
        vin[5] = 10'h155; one_shot(5, 0, 1'b0, 1'b1);
        rd(11, v); chk(v == 3, "R7 odd byte unchanged", v, 3);

        // R12: request and configuration changes mid-run are ignored
        vin[2] = 10'd600;
        cfg_mode = 2'd0; cfg_chan = 3'd2; cfg_div = 2'd0; cfg_res10 = 1'b1; cfg_sh = 1'b0;
        pulse_start();
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 20) begin start_set = 1'b1; cfg_chan = 3'd6; cfg_res10 = 1'b0; cfg_div = 2'd2; end
            if (n == 21) begin start_set = 1'b0; end
            if (done_o) break;
        end
        chk(n == 59, "R12 timing kept", n, 59);
        chk(busy_o == 0, "R12 no restart", int'(busy_o), 0);
        cfg_res10 = 1'b1;
        expect_store(2, 1'b1, "R12 original channel");
        rd(12, v); chk(v == exp_b[12], "R12 other channel untouched", v, exp_b[12]);

        // R9: repeat mode
        vin[3] = 10'd777;
        cfg_mode = 2'd1; cfg_chan = 3'd3; cfg_div = 2'd1; cfg_res10 = 1'b1; cfg_sh = 1'b1;
        pulse_start();
        wait_done(n);
        chk(n == 66, "R9 first pass", n, 66);
        expect_store(3, 1'b1, "R9 first result");
        vin[3] = 10'd123;
        wait_done(n);
        chk(n == 66, "R9 spacing", n, 66);
        chk(busy_o == 1, "R9 still running", int'(busy_o), 1);
        expect_store(3, 1'b1, "R9 fresh result");
        repeat (30) @(negedge clk);
        // R12: clearing the run flag stops it
        start_clr = 1'b1;
        @(negedge clk); start_clr = 1'b0;
        chk(busy_o == 0, "R12 stop", int'(busy_o), 0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); if (done_o) n++;
        end
        chk(n == 0, "R12 no done after stop", n, 0);

        // R10: single pass over inputs 0..3
        for (int c = 0; c < 4; c++) vin[c] = 10'(c * 250 + 40);
        cfg_mode = 2'd2; cfg_chan = 3'd3; cfg_div = 2'd0; cfg_res10 = 1'b0; cfg_sh = 1'b1;
        pulse_start();
        for (int c = 0; c < 4; c++) begin
            wait_done(n);
            chk(n == 28, "R10 spacing", n, 28);
            if (c < 3) chk(int'(ain_sel_o) == c + 1, "R10 next input", int'(ain_sel_o), c + 1);
            chk(busy_o == (c < 3), "R10 busy", int'(busy_o), int'(c < 3));
            expect_store(c, 1'b0, "R10 result");
        end

        // R11: endless pass over inputs 0..1
        vin[0] = 10'd900; vin[1] = 10'd17;
        cfg_mode = 2'd3; cfg_chan = 3'd1; cfg_div = 2'd1; cfg_res10 = 1'b1; cfg_sh = 1'b0;
        pulse_start();
        for (int j = 0; j < 4; j++) begin
            wait_done(n);
            chk(n == 118, "R11 spacing", n, 118);
            chk(int'(ain_sel_o) == ((j + 1) % 2), "R11 wrap order", int'(ain_sel_o), (j + 1) % 2);
            chk(busy_o == 1, "R11 running", int'(busy_o), 1);
            expect_store(j % 2, 1'b1, "R11 result");
        end
        @(negedge clk); start_clr = 1'b1;
        @(negedge clk); start_clr = 1'b0;
        chk(busy_o == 0, "R11 stopped", int'(busy_o), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule